// File: doc/BRIEF.md
# Scratchpad Region Hit Controller

This block sits in front of a reconfigurable cache whose ways can be handed over, one at a time, to software as scratchpad storage. For every access it decides whether the address falls inside a scratchpad window. If it does, it produces the array index and write value that the scratchpad needs. If it does not, it passes the regular cache set index and tag field through so that ordinary cache lookup carries on unchanged.

There are two windows. The first is a 512-byte window that is stored in the tag arrays. The second is a 4 KB window that is stored in the data arrays. Both use the same controller, built twice with different parameters.

A small configuration port holds three registers: a base address for each window and a per-way enable mask that both windows share. An access counts as a scratchpad hit only when its address lies inside a window and the way that the address selects is enabled in the mask. The path from address to outputs is purely combinational. Only the configuration registers are clocked.

Top module: `spm_hit_ctrl`

## Requirements
- R1: After reset both bases are 0 and the way mask is 0000, so no address produces a hit in either window.
- R2: `ts_hit` is 1 exactly when addr[31:9] equals tag-window base bits [31:9] and the mask bit selected by addr[8:7] is 1.
- R3: `ds_hit` is 1 exactly when addr[31:12] equals data-window base bits [31:12] and the mask bit selected by addr[11:10] is 1.
- R4: On a tag-window hit, `ts_index` is addr[6:2] and `ts_wval` is `wdata`.
- R5: On a data-window hit, `ds_index` is addr[9:5] and `ds_wval` is `wdata`.
- R6: On a miss in a window, that window's index output is addr[9:5] and its write value is the regular tag field addr[31:10], zero-extended to 32 bits.
- R7: `ts_way` always equals addr[8:7] and `ds_way` always equals addr[11:10], whether or not there is a hit.
- R8: A configuration write with `cfg_we`=1 updates one register at the next clock edge. The select encoding is 00 for the tag-window base, 01 for the data-window base and 10 for the way mask (`cfg_wdata`[3:0], bit n for way n). Select 11 changes nothing. Base bits below the window size are ignored.
- R9: An address inside a window whose selected way has its mask bit at 0 gives a miss, with the miss outputs of R6.
- R10: The hit, index and write-value outputs follow a change on `addr` or `wdata` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| addr | input | 32 | Access byte address |
| wdata | input | 32 | Access write data |
| ts_hit | output | 1 | Tag-window scratchpad hit |
| ts_index | output | 5 | Tag-array index (scratchpad or regular) |
| ts_wval | output | 32 | Tag-array write value |
| ts_way | output | 2 | Way decoded for the tag window |
| ds_hit | output | 1 | Data-window scratchpad hit |
| ds_index | output | 5 | Data-array index (scratchpad or regular) |
| ds_wval | output | 32 | Data-array write value |
| ds_way | output | 2 | Way decoded for the data window |

## Verification
The assertions assume that `addr`, `wdata` and the configuration inputs are stable around each rising clock edge. They also assume that a configuration write and an access are never checked in the same cycle, since the outputs relate to the registers as they stand after the edge.

The stimulus changes inputs only on falling edges. It issues configuration writes in cycles of their own and checks accesses only in later cycles. The addresses it chooses sit on and next to window edges, and they cover every way with its mask bit both set and cleared.

// File: rtl/spm_pkg.sv
package spm_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned WAYS   = 4;

    typedef enum logic [1:0] {
        CFG_TAG_BASE  = 2'b00,
        CFG_DATA_BASE = 2'b01,
        CFG_WAY_MASK  = 2'b10,
        CFG_NONE      = 2'b11
    } cfg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] tag_base;
        logic [ADDR_W-1:0] data_base;
        logic [WAYS-1:0]   way_mask;
    } cfg_state_t;

endpackage

// File: rtl/spm_cfg_regs.sv
module spm_cfg_regs
    import spm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] tag_base,
    output logic [ADDR_W-1:0] data_base,
    output logic [WAYS-1:0]   way_mask
);

    cfg_state_t cfg_d;
    cfg_state_t cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            unique case (cfg_sel_e'(cfg_sel))
                CFG_TAG_BASE:  cfg_d.tag_base  = cfg_wdata[ADDR_W-1:0];
                CFG_DATA_BASE: cfg_d.data_base = cfg_wdata[ADDR_W-1:0];
                CFG_WAY_MASK:  cfg_d.way_mask  = cfg_wdata[WAYS-1:0];
                default:       cfg_d           = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign tag_base  = cfg_q.tag_base;
    assign data_base = cfg_q.data_base;
    assign way_mask  = cfg_q.way_mask;

endmodule

// File: rtl/spm_region_ctrl.sv
module spm_region_ctrl #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned WAYS        = 4,
    parameter int unsigned REGION_LOG2 = 9,
    parameter int unsigned WAY_LSB     = 7,
    parameter int unsigned SPM_IDX_LSB = 2,
    parameter int unsigned IDX_LSB     = 5,
    parameter int unsigned IDX_W       = 5,
    parameter int unsigned TAG_LSB     = 10
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [ADDR_W-1:0]       base,
    input  logic [WAYS-1:0]         way_mask,
    output logic                    hit,
    output logic [IDX_W-1:0]        index,
    output logic [DATA_W-1:0]       wval,
    output logic [$clog2(WAYS)-1:0] way
);

    localparam int unsigned WAY_W = $clog2(WAYS);
    localparam int unsigned TAG_W = ADDR_W - TAG_LSB;

    logic              in_window;
    logic              way_on;
    logic [IDX_W-1:0]  spm_index;
    logic [IDX_W-1:0]  reg_index;
    logic [TAG_W-1:0]  reg_tag;

    // Window compare on the bits above the window size; base low bits unused
    assign in_window = (addr[ADDR_W-1:REGION_LOG2] == base[ADDR_W-1:REGION_LOG2]);
    assign way       = addr[WAY_LSB +: WAY_W];
    assign way_on    = way_mask[way];
    assign hit       = in_window && way_on;

    assign spm_index = addr[SPM_IDX_LSB +: IDX_W];
    assign reg_index = addr[IDX_LSB +: IDX_W];
    assign reg_tag   = addr[ADDR_W-1:TAG_LSB];

    // Index and write-value selection
    always_comb begin
        if (hit) begin
            index = spm_index;
            wval  = wdata;
        end else begin
            index = reg_index;
            wval  = DATA_W'(reg_tag);
        end
    end

endmodule

// File: rtl/spm_hit_ctrl.sv
module spm_hit_ctrl
    import spm_pkg::*;
#(
    parameter int unsigned IDX_W       = 5,
    parameter int unsigned TS_LOG2     = 9,
    parameter int unsigned TS_WAY_LSB  = 7,
    parameter int unsigned DS_LOG2     = 12,
    parameter int unsigned DS_WAY_LSB  = 10,
    localparam int unsigned WAY_W      = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ts_hit,
    output logic [IDX_W-1:0]  ts_index,
    output logic [DATA_W-1:0] ts_wval,
    output logic [WAY_W-1:0]  ts_way,
    output logic              ds_hit,
    output logic [IDX_W-1:0]  ds_index,
    output logic [DATA_W-1:0] ds_wval,
    output logic [WAY_W-1:0]  ds_way
);

    logic [ADDR_W-1:0] tag_base_q;
    logic [ADDR_W-1:0] data_base_q;
    logic [WAYS-1:0]   way_mask_q;

    spm_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .tag_base  (tag_base_q),
        .data_base (data_base_q),
        .way_mask  (way_mask_q)
    );

    // Tag window: word index inside one way
    spm_region_ctrl #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .WAYS        (WAYS),
        .REGION_LOG2 (TS_LOG2),
        .WAY_LSB     (TS_WAY_LSB),
        .SPM_IDX_LSB (2),
        .IDX_LSB     (5),
        .IDX_W       (IDX_W),
        .TAG_LSB     (10)
    ) u_ts (
        .addr     (addr),
        .wdata    (wdata),
        .base     (tag_base_q),
        .way_mask (way_mask_q),
        .hit      (ts_hit),
        .index    (ts_index),
        .wval     (ts_wval),
        .way      (ts_way)
    );

    // Data window: line index inside one way
    spm_region_ctrl #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .WAYS        (WAYS),
        .REGION_LOG2 (DS_LOG2),
        .WAY_LSB     (DS_WAY_LSB),
        .SPM_IDX_LSB (5),
        .IDX_LSB     (5),
        .IDX_W       (IDX_W),
        .TAG_LSB     (10)
    ) u_ds (
        .addr     (addr),
        .wdata    (wdata),
        .base     (data_base_q),
        .way_mask (way_mask_q),
        .hit      (ds_hit),
        .index    (ds_index),
        .wval     (ds_wval),
        .way      (ds_way)
    );

endmodule

// File: rtl/spm_hit_ctrl_chk.sv
module spm_hit_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [1:0]  cfg_sel,
    input logic [31:0] addr,
    input logic [31:0] wdata,
    input logic [31:0] tag_base_q,
    input logic [31:0] data_base_q,
    input logic [3:0]  way_mask_q,
    input logic        ts_hit,
    input logic [4:0]  ts_index,
    input logic [31:0] ts_wval,
    input logic [1:0]  ts_way,
    input logic        ds_hit,
    input logic [4:0]  ds_index,
    input logic [31:0] ds_wval,
    input logic [1:0]  ds_way
);

    a_r1_no_hit_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (way_mask_q == 4'b0000) |-> (!ts_hit && !ds_hit));

    a_r2_ts_hit_cond: assert property (@(posedge clk) disable iff (!rst_n)
        ts_hit |-> (addr[31:9] == tag_base_q[31:9]));

    a_r3_ds_hit_cond: assert property (@(posedge clk) disable iff (!rst_n)
        ds_hit |-> (addr[31:12] == data_base_q[31:12]));

    a_r4_ts_hit_fields: assert property (@(posedge clk) disable iff (!rst_n)
        ts_hit |-> (ts_index == addr[6:2] && ts_wval == wdata));

    a_r5_ds_hit_fields: assert property (@(posedge clk) disable iff (!rst_n)
        ds_hit |-> (ds_index == addr[9:5] && ds_wval == wdata));

    a_r6_miss_fields: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_hit |-> (ts_index == addr[9:5] && ts_wval == {10'b0, addr[31:10]}));

    a_r7_way_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_way == addr[8:7] && ds_way == addr[11:10]));

    a_r8_unused_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 2'b11) |=>
        ($stable(tag_base_q) && $stable(data_base_q) && $stable(way_mask_q)));

    a_r9_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_hit |-> way_mask_q[addr[8:7]]) and (ds_hit |-> way_mask_q[addr[11:10]]));

endmodule

bind spm_hit_ctrl spm_hit_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .addr        (addr),
    .wdata       (wdata),
    .tag_base_q  (tag_base_q),
    .data_base_q (data_base_q),
    .way_mask_q  (way_mask_q),
    .ts_hit      (ts_hit),
    .ts_index    (ts_index),
    .ts_wval     (ts_wval),
    .ts_way      (ts_way),
    .ds_hit      (ds_hit),
    .ds_index    (ds_index),
    .ds_wval     (ds_wval),
    .ds_way      (ds_way)
);

// File: tb/sim_spm_hit_ctrl.sv
module sim_spm_hit_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'b00;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        ts_hit, ds_hit;
    logic [4:0]  ts_index, ds_index;
    logic [31:0] ts_wval, ds_wval;
    logic [1:0]  ts_way, ds_way;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Bench-side model of the configuration
    logic [31:0] m_tbase = '0;
    logic [31:0] m_dbase = '0;
    logic [3:0]  m_mask  = '0;

    typedef struct {
        string       tag;
        logic        ts_hit;
        logic [4:0]  ts_index;
        logic [31:0] ts_wval;
        logic [1:0]  ts_way;
        logic        ds_hit;
        logic [4:0]  ds_index;
        logic [31:0] ds_wval;
        logic [1:0]  ds_way;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;

    spm_hit_ctrl u0 (
        .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_sel (cfg_sel),
        .cfg_wdata (cfg_wdata), .addr (addr), .wdata (wdata),
        .ts_hit (ts_hit), .ts_index (ts_index), .ts_wval (ts_wval), .ts_way (ts_way),
        .ds_hit (ds_hit), .ds_index (ds_index), .ds_wval (ds_wval), .ds_way (ds_way)
    );

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            2'b00: m_tbase = val;
            2'b01: m_dbase = val;
            2'b10: m_mask  = val[3:0];
            default: ;
        endcase
    endtask

    task automatic access(input logic [31:0] a, input logic [31:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        addr = a; wdata = d;
        e.tag      = tag;
        e.ts_way   = a[8:7];
        e.ds_way   = a[11:10];
        e.ts_hit   = (a[31:9] == m_tbase[31:9]) && m_mask[a[8:7]];
        e.ds_hit   = (a[31:12] == m_dbase[31:12]) && m_mask[a[11:10]];
        e.ts_index = e.ts_hit ? a[6:2] : a[9:5];
        e.ts_wval  = e.ts_hit ? d : {10'b0, a[31:10]};
        e.ds_index = a[9:5];
        e.ds_wval  = e.ds_hit ? d : {10'b0, a[31:10]};
        q.push_back(e);
    endtask

    // Monitor: compare a few ns after each input change (same cycle, R10)
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (ts_hit !== e.ts_hit || ts_index !== e.ts_index || ts_wval !== e.ts_wval ||
                    ts_way !== e.ts_way || ds_hit !== e.ds_hit || ds_index !== e.ds_index ||
                    ds_wval !== e.ds_wval || ds_way !== e.ds_way) begin
                    failures++;
                    $display("FAIL %s addr=%h act ts=%b/%h/%h/%h ds=%b/%h/%h/%h exp ts=%b/%h/%h/%h ds=%b/%h/%h/%h",
                        e.tag, addr, ts_hit, ts_index, ts_wval, ts_way, ds_hit, ds_index, ds_wval, ds_way,
                        e.ts_hit, e.ts_index, e.ts_wval, e.ts_way, e.ds_hit, e.ds_index, e.ds_wval, e.ds_way);
                end
            end
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, no hits anywhere
        access(32'h0000_0000, 32'hDEAD_BEEF, "R1 reset base0 mask0");
        access(32'h0000_0C84, 32'h1234_5678, "R1 reset other way");
        // R8: configure, tag base with low bits set (ignored)
        cfg_write(2'b00, 32'h0001_0237);
        cfg_write(2'b01, 32'h0002_0000);
        cfg_write(2'b10, 32'h0000_0005);
        // R2/R4 tag window hits on enabled ways 0 and 2
        access(32'h0001_0214, 32'hA5A5_0001, "R2 R4 R8 tag way0 hit");
        access(32'h0001_037C, 32'hA5A5_0002, "R2 R4 tag way2 hit");
        // R9 disabled ways 1 and 3
        access(32'h0001_0284, 32'hA5A5_0003, "R9 tag way1 masked");
        access(32'h0001_03FC, 32'hA5A5_0004, "R9 tag way3 masked");
        // R6 edges outside the tag window
        access(32'h0001_01FC, 32'hA5A5_0005, "R6 below tag window");
        access(32'h0001_0400, 32'hA5A5_0006, "R6 above tag window");
        // R3/R5 data window
        access(32'h0002_0020, 32'h5A5A_0001, "R3 R5 data way0 hit");
        access(32'h0002_0BE0, 32'h5A5A_0002, "R3 R5 data way2 hit");
        access(32'h0002_0400, 32'h5A5A_0003, "R9 data way1 masked");
        access(32'h0002_1000, 32'h5A5A_0004, "R6 above data window");
        access(32'h0001_FFFC, 32'h5A5A_0005, "R6 below data window");
        // R10: same address, new write data, same cycle result
        access(32'h0002_0020, 32'h0BAD_F00D, "R10 wdata follows");
        access(32'hFFFF_FFFF, 32'h0000_0000, "R7 R6 all ones addr");
        // R8 unused select must not change anything
        cfg_write(2'b11, 32'hFFFF_FFFF);
        access(32'h0001_0214, 32'h1111_2222, "R8 sel11 tag hit kept");
        access(32'h0001_0284, 32'h3333_4444, "R8 sel11 mask kept");
        access(32'h0002_0BE0, 32'h5555_6666, "R8 sel11 data base kept");
        // Enable all ways
        cfg_write(2'b10, 32'h0000_000F);
        access(32'h0001_0284, 32'h7777_8888, "R2 R8 tag way1 now on");
        access(32'h0002_0C40, 32'h9999_AAAA, "R3 R8 data way3 now on");
        // Move tag window, old one must miss
        cfg_write(2'b00, 32'h0002_0E00);
        access(32'h0001_0214, 32'hCCCC_0001, "R2 R8 old tag window miss");
        access(32'h0002_0E88, 32'hCCCC_0002, "R2 R3 both windows hit");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule